// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is a serial-peripheral master that sweeps the input channels of a successive-approximation converter speaking in 16-bit frames. A one-cycle start pulse together with a channel-enable mask launches a scan. The sequencer then issues one conversion request per enabled channel, lowest index first, and follows them with two all-zero padding frames. Between frames it releases chip select.

The converter answers each request two frames after it was sent. The sequencer therefore keeps a short record of which channel each frame asked for. When a response arrives, it compares the 4-bit channel tag in the upper bits of the word with the channel it expects. It then emits a one-cycle result beat carrying the channel number, the conversion value, a tag-mismatch error flag and a final-beat flag. The serial clock is derived from the system clock by a parameterised divider. The converter resolution (8, 10 or 12 bits) is a parameter.

Top module: `adc_scan_seq`

## Requirements
- R1: Every frame is exactly 16 serial clocks long. Chip select goes high after each frame and stays high for at least one cycle before the next frame. The serial clock is low whenever chip select is high.
- R2: A request frame has bit 12 set, the channel number in bits 10:7, and every other bit zero.
- R3: The enable mask is captured at start. Enabled channels are requested in ascending index order, and each enabled channel is requested exactly once.
- R4: A scan of N enabled channels uses exactly N+2 frames. The last two frames are all zero.
- R5: The response to frame k arrives during frame k+2. Responses in the first two frames of a scan are discarded. Every later frame yields exactly one result beat, whose channel field is the channel requested two frames earlier, so beats follow request order.
- R6: The result value is bits 11 down to 12−R of the response word, with R the resolution parameter, zero-extended to 12 bits.
- R7: The error flag is 1 when response bits 15:12 differ from the expected channel and 0 when they match. The channel field always shows the requested channel.
- R8: A result beat is valid for one cycle. The final-beat flag is 1 on the last beat of a scan only.
- R9: Busy is high in the cycle after an accepted start and stays high through the cycle of the final beat. It is low in the following cycle.
- R10: A start pulse while busy is high changes neither the running scan nor the frames that follow. A start pulse with an all-zero mask starts no scan and leaves busy low.
- R11: Data goes out MSB first. The output data line changes only while the serial clock is low, and input data is sampled on the serial clock's rising edge. Each serial clock phase lasts HALF_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start_i | input | 1 | One-cycle start request |
| chan_en_i | input | NUM_CH | Channel-enable mask, bit i enables channel i |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the converter |
| res_valid_o | output | 1 | Result beat strobe |
| res_chan_o | output | 4 | Channel of the result |
| res_value_o | output | 12 | Zero-extended conversion value |
| res_err_o | output | 1 | Channel-tag mismatch flag |
| res_last_o | output | 1 | Final beat of the scan |
| busy_o | output | 1 | Scan in progress |

## Verification
A result belongs to the frame two positions ahead of its request. Its beat shows up one system cycle after chip select rises at the end of that later frame. Busy rises one cycle after the start pulse is sampled and falls one cycle after the final beat. The bench's converter model answers every frame with the word built from the command two frames back, so the expected sequence of commands and beats is fixed in advance and queued. The monitor takes each beat off the queue at the falling clock edge, whenever it appears, and checks busy one cycle after the final beat instead of counting absolute cycles.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int FRAME_W   = 16;
  localparam int TAG_W     = 4;
  localparam int MAX_CH    = 16;
  localparam int REQ_BIT   = 12;
  localparam int CH_LSB    = 7;
  localparam int PIPE_LAT  = 2;   // frames between a request and its answer
  localparam int VAL_W     = 12;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_SHIFT,
    SH_GAP
  } shf_state_e;

  typedef struct packed {
    logic              last;
    logic              err;
    logic [TAG_W-1:0]  chan;
    logic [VAL_W-1:0]  value;
  } scan_result_t;

  // Conversion request word for one channel
  function automatic logic [FRAME_W-1:0] build_request(input logic [TAG_W-1:0] ch);
    logic [FRAME_W-1:0] w;
    w                       = '0;
    w[REQ_BIT]              = 1'b1;
    w[CH_LSB +: TAG_W]      = ch;
    return w;
  endfunction

  // Index of the lowest set bit (0 when none is set)
  function automatic logic [TAG_W-1:0] lowest_set(input logic [MAX_CH-1:0] m);
    logic [TAG_W-1:0] idx;
    idx = '0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (m[i]) idx = TAG_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [4:0] ones_in(input logic [MAX_CH-1:0] m);
    logic [4:0] n;
    n = '0;
    for (int i = 0; i < MAX_CH; i++) n = n + 5'(m[i]);
    return n;
  endfunction

endpackage

// File: rtl/adc_scan_sclk_div.sv
module adc_scan_sclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_scan_shifter.sv
module adc_scan_shifter
  import adc_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] tx_i,
  input  logic               tick_i,
  input  logic               miso_i,
  output logic               run_o,
  output logic               ready_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o,
  output logic               sclk_o,
  output logic               cs_n_o,
  output logic               mosi_o
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  shf_state_e         st_q, st_d;
  logic               sclk_q, sclk_d;
  logic               cs_q, cs_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               done_q, done_d;

  assign run_o   = (st_q != SH_IDLE);
  assign ready_o = (st_q == SH_IDLE);
  assign done_o  = done_q;
  assign rx_o    = rx_q;
  assign sclk_o  = sclk_q;
  assign cs_n_o  = cs_q;
  assign mosi_o  = tx_q[FRAME_W-1];

  always_comb begin
    st_d   = st_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    done_d = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (go_i) begin
          st_d   = SH_SHIFT;
          cs_d   = 1'b0;
          sclk_d = 1'b0;
          tx_d   = tx_i;
          bit_d  = '0;
        end
      end
      SH_SHIFT: begin
        if (tick_i) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rx_d   = {rx_q[FRAME_W-2:0], miso_i};
          end else begin
            sclk_d = 1'b0;
            tx_d   = {tx_q[FRAME_W-2:0], 1'b0};
            if (bit_q == BIT_LAST) begin
              cs_d   = 1'b1;
              st_d   = SH_GAP;
              done_d = 1'b1;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      SH_GAP: begin
        if (tick_i) st_d = SH_IDLE;
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/adc_scan_unpack.sv
module adc_scan_unpack
  import adc_scan_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic [FRAME_W-1:0] word_i,
  input  logic [TAG_W-1:0]   exp_chan_i,
  output logic [VAL_W-1:0]   value_o,
  output logic               err_o
);

  localparam int SHIFT = VAL_W - RES_BITS;

  generate
    if (SHIFT == 0) begin : g_full
      assign value_o = word_i[VAL_W-1:0];
    end else begin : g_shifted
      assign value_o = word_i[VAL_W-1:0] >> SHIFT;
    end
  endgenerate

  assign err_o = (word_i[FRAME_W-1 -: TAG_W] != exp_chan_i);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [NUM_CH-1:0]  mask_i,
  input  logic               sh_ready_i,
  input  logic               sh_done_i,
  input  logic [FRAME_W-1:0] sh_rx_i,
  output logic               sh_go_o,
  output logic [FRAME_W-1:0] sh_tx_o,
  output logic               res_valid_o,
  output scan_result_t       res_o,
  output logic               busy_o
);

  localparam int FC_W = $clog2(NUM_CH + PIPE_LAT + 1);
  localparam logic [FC_W-1:0] LAT_F = FC_W'(PIPE_LAT);

  seq_state_e        state_q, state_d;
  logic [MAX_CH-1:0] rem_q, rem_d;
  logic [FC_W-1:0]   tot_q, tot_d;
  logic [FC_W-1:0]   idx_q, idx_d;
  logic              pend_q, pend_d;
  logic [TAG_W-1:0]  exp_q, exp_d;
  logic [TAG_W-1:0]  hist_q [PIPE_LAT];
  logic [TAG_W-1:0]  hist_d [PIPE_LAT];
  logic              rv_q, rv_d;
  scan_result_t      res_q, res_d;

  logic [MAX_CH-1:0] mask_w;
  logic [TAG_W-1:0]  next_ch;
  logic [VAL_W-1:0]  unp_value;
  logic              unp_err;
  logic              last_frame;

  assign mask_w     = MAX_CH'(mask_i);
  assign next_ch    = lowest_set(rem_q);
  assign last_frame = (idx_q == tot_q - 1'b1);

  adc_scan_unpack #(.RES_BITS(RES_BITS)) unpack_i (
    .word_i     (sh_rx_i),
    .exp_chan_i (exp_q),
    .value_o    (unp_value),
    .err_o      (unp_err)
  );

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    tot_d   = tot_q;
    idx_d   = idx_q;
    pend_d  = pend_q;
    exp_d   = exp_q;
    hist_d  = hist_q;
    rv_d    = 1'b0;
    res_d   = res_q;
    sh_go_o = 1'b0;
    sh_tx_o = '0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_i && (|mask_w)) begin
          rem_d   = mask_w;
          tot_d   = FC_W'(ones_in(mask_w)) + LAT_F;
          idx_d   = '0;
          pend_d  = 1'b0;
          state_d = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (!pend_q && sh_ready_i) begin
          sh_go_o = 1'b1;
          pend_d  = 1'b1;
          exp_d   = hist_q[PIPE_LAT-1];
          for (int i = 1; i < PIPE_LAT; i++) hist_d[i] = hist_q[i-1];
          if (|rem_q) begin
            sh_tx_o   = build_request(next_ch);
            rem_d     = rem_q & ~(MAX_CH'(1) << next_ch);
            hist_d[0] = next_ch;
          end else begin
            hist_d[0] = '0;
          end
        end
        if (pend_q && sh_done_i) begin
          pend_d = 1'b0;
          idx_d  = idx_q + 1'b1;
          if (idx_q >= LAT_F) begin
            rv_d        = 1'b1;
            res_d.chan  = exp_q;
            res_d.value = unp_value;
            res_d.err   = unp_err;
            res_d.last  = last_frame;
          end
          if (last_frame) state_d = SEQ_FINISH;
        end
      end
      SEQ_FINISH: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      tot_q   <= '0;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      exp_q   <= '0;
      for (int i = 0; i < PIPE_LAT; i++) hist_q[i] <= '0;
      rv_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      tot_q   <= tot_d;
      idx_q   <= idx_d;
      pend_q  <= pend_d;
      exp_q   <= exp_d;
      hist_q  <= hist_d;
      rv_q    <= rv_d;
      res_q   <= res_d;
    end
  end

  assign res_valid_o = rv_q;
  assign res_o       = res_q;
  assign busy_o      = (state_q != SEQ_IDLE);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start_i,
  input  logic [NUM_CH-1:0] chan_en_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  output logic              res_valid_o,
  output logic [3:0]        res_chan_o,
  output logic [11:0]       res_value_o,
  output logic              res_err_o,
  output logic              res_last_o,
  output logic              busy_o
);

  logic               sh_go, sh_ready, sh_done, sh_run, tick;
  logic [FRAME_W-1:0] sh_tx, sh_rx;
  scan_result_t       res;

  adc_scan_sclk_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (sh_run),
    .tick_o (tick)
  );

  adc_scan_shifter shf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (sh_go),
    .tx_i    (sh_tx),
    .tick_i  (tick),
    .miso_i  (miso_i),
    .run_o   (sh_run),
    .ready_o (sh_ready),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sclk_o  (sclk_o),
    .cs_n_o  (cs_n_o),
    .mosi_o  (mosi_o)
  );

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (scan_start_i),
    .mask_i      (chan_en_i),
    .sh_ready_i  (sh_ready),
    .sh_done_i   (sh_done),
    .sh_rx_i     (sh_rx),
    .sh_go_o     (sh_go),
    .sh_tx_o     (sh_tx),
    .res_valid_o (res_valid_o),
    .res_o       (res),
    .busy_o      (busy_o)
  );

  assign res_chan_o  = res.chan;
  assign res_value_o = res.value;
  assign res_err_o   = res.err;
  assign res_last_o  = res.last;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_o,
  input logic cs_n_o,
  input logic mosi_o,
  input logic res_valid_o,
  input logic res_last_o,
  input logic busy_o
);

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> cs_n_o);                                   // R1

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);                                         // R1

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));              // R11

  AST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);                               // R8

  AST_BEAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> busy_o);                                     // R9

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_last_o) |=> !busy_o);                    // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cs_n_o);                                         // R10

endmodule

bind adc_scan_seq adc_scan_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk_o      (sclk_o),
  .cs_n_o      (cs_n_o),
  .mosi_o      (mosi_o),
  .res_valid_o (res_valid_o),
  .res_last_o  (res_last_o),
  .busy_o      (busy_o)
);

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;

  localparam int NCH  = 16;
  localparam int RB   = 10;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_start = 1'b0;
  logic [NCH-1:0] chan_en = '0;
  logic miso = 1'b0;
  logic sclk, cs_n, mosi, res_valid, res_err, res_last, busy;
  logic [3:0]  res_chan;
  logic [11:0] res_value;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int frames_seen = 0;
  int corrupt_ch = -1;
  int salt_g = 0;
  bit slave_en = 1'b0;
  bit busy_drop_due = 1'b0;
  int hi_cnt = 0;

  logic [15:0] cmd_q [$];
  logic [17:0] res_q [$];
  logic [15:0] s_rx = '0, s_tx = '0, h0 = '0, h1 = '0;
  int s_bits = 0;

  always #10 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NCH), .RES_BITS(RB), .HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_start_i(scan_start), .chan_en_i(chan_en),
    .miso_i(miso), .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi),
    .res_valid_o(res_valid), .res_chan_o(res_chan), .res_value_o(res_value),
    .res_err_o(res_err), .res_last_o(res_last), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] conv(input int ch, input int salt);
    return 12'((ch * 331 + salt * 97 + 5) & 12'hFFF);
  endfunction

  function automatic logic [15:0] answer(input logic [15:0] cmd);
    logic [3:0] ch, tag;
    if (!cmd[12]) return 16'h0000;
    ch  = cmd[10:7];
    tag = (int'(ch) == corrupt_ch) ? (ch ^ 4'h1) : ch;
    return {tag, conv(int'(ch), salt_g)};
  endfunction

  // Converter model: answers with the command from two frames back
  always @(negedge cs_n) begin
    if (slave_en) begin
      s_tx   = answer(h1);
      miso   = s_tx[15];
      s_bits = 0;
    end
  end

  always @(posedge sclk) begin
    if (slave_en && !cs_n) begin
      s_rx = {s_rx[14:0], mosi};
      s_bits++;
    end
  end

  always @(negedge sclk) begin
    if (slave_en && !cs_n) begin
      s_tx = {s_tx[14:0], 1'b0};
      miso = s_tx[15];
    end
  end

  always @(posedge cs_n) begin
    if (slave_en) begin
      logic [15:0] e;
      frames_seen++;
      check(s_bits == 16, "R1", "clocks per frame", s_bits, 16);
      if (cmd_q.size() == 0) begin
        check(1'b0, "R10", "unexpected frame", int'(s_rx), 0);
      end else begin
        e = cmd_q.pop_front();
        check(s_rx == e, "R2", "frame word", int'(s_rx), int'(e));
      end
      h1 = h0;
      h0 = s_rx;
    end
  end

  // Result monitor and clock-phase monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_drop_due) begin
        check(!busy, "R9", "busy after final beat", int'(busy), 0);
        busy_drop_due = 1'b0;
      end
      if (res_valid) begin
        if (res_q.size() == 0) begin
          check(1'b0, "R5", "unexpected beat", int'(res_chan), 0);
        end else begin
          logic [17:0] e;
          e = res_q.pop_front();
          check(res_chan == e[15:12], "R5", "channel", int'(res_chan), int'(e[15:12]));
          check(res_value == e[11:0], "R6", "value", int'(res_value), int'(e[11:0]));
          check(res_err == e[16], "R7", "error flag", int'(res_err), int'(e[16]));
          check(res_last == e[17], "R8", "final flag", int'(res_last), int'(e[17]));
        end
        if (res_last) busy_drop_due = 1'b1;
      end
      if (sclk) hi_cnt++;
      else if (hi_cnt != 0) begin
        check(hi_cnt == HALF, "R11", "clock high phase", hi_cnt, HALF);
        hi_cnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Driver: queues expected frames and beats, then launches the scan
  task automatic run_scan(input logic [15:0] mask, input int bad_ch,
                          input int salt, input bit intrude);
    int n = 0;
    int got = 0;
    int f0;
    corrupt_ch = bad_ch;
    salt_g     = salt;
    for (int i = 0; i < NCH; i++) if (mask[i]) n++;
    for (int i = 0; i < NCH; i++) begin
      if (mask[i]) begin
        logic [11:0] v;
        cmd_q.push_back(16'h1000 | (16'(i) << 7));
        v = conv(i, salt) >> (12 - RB);
        got++;
        res_q.push_back({(got == n), (i == bad_ch), 4'(i), v});
      end
    end
    cmd_q.push_back(16'h0000);
    cmd_q.push_back(16'h0000);
    f0 = frames_seen;
    @(negedge clk);
    chan_en    = mask;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    check(busy, "R9", "busy after start", int'(busy), 1);
    if (intrude) begin
      repeat (150) @(negedge clk);
      chan_en    = 16'hFFFF;
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      chan_en    = 16'h0000;
    end
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    check(frames_seen - f0 == n + 2, "R4", "frames per scan", frames_seen - f0, n + 2);
    check(cmd_q.size() == 0, "R3", "requests left unsent", cmd_q.size(), 0);
    check(res_q.size() == 0, "R5", "beats missing", res_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    slave_en = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1, "R1", "reset chip select", int'(cs_n), 1);
    check(sclk == 1'b0, "R1", "reset serial clock", int'(sclk), 0);
    check(busy == 1'b0, "R9", "reset busy", int'(busy), 0);
    check(res_valid == 1'b0, "R8", "reset beat", int'(res_valid), 0);

    run_scan(16'h0001, -1, 1, 1'b0);          // single channel
    run_scan(16'h8421, -1, 2, 1'b0);          // sparse ascending, R3
    run_scan(16'hFFFF, -1, 3, 1'b0);          // all channels
    run_scan(16'h0030, 5, 4, 1'b0);           // tag mismatch on channel 5, R7
    run_scan(16'h0106, -1, 5, 1'b1);          // start during scan ignored, R10

    begin : zero_mask_r10
      int f0;
      f0 = frames_seen;
      @(negedge clk);
      chan_en    = '0;
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      check(!busy, "R10", "busy on empty mask", int'(busy), 0);
      repeat (100) @(negedge clk);
      check(frames_seen == f0, "R10", "frames on empty mask", frames_seen - f0, 0);
    end

    run_scan(16'h4000, -1, 6, 1'b0);          // after an ignored start

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule